// File: doc/BRIEF.md
# Multi-Sample Hit Timing Selector

This block sits behind the per-channel digitiser of a silicon strip readout. For every strip it gathers a short group of shaped-pulse samples, taken one clock apart. One, two, three or four readout requests, issued three clocks apart, each add three samples to the group. When the last sample of a strip's group arrives, the block decides whether the pulse peaked in time with the trigger, and rejects off-time background on that basis.

Samples from different strips may be interleaved freely; each one carries its strip address and its position within the group. The block keeps a per-strip sample store. The verdict needs two things: a run of three consecutive above-threshold samples, and a peak-shaped ordering of the first three samples. The strict ordering requires the third sample to sit between the first and the peak. The relaxed ordering only asks that the second sample be the largest. When six or more samples exist, the block also raises a pile-up flag for a neighbouring pulse. A 5-bit trigger-to-clock phase value travels with each accepted hit.

Top module: `hts_selector`

## Requirements
- R1: Each sample is stored under its own strip address and position index; samples of different strips may interleave without affecting each other's verdict.
- R2: The group length is 3*(cfg_ntrig+1) samples. Exactly one hit_valid pulse appears, in the cycle after the sample whose index equals length-1 is presented, and it carries that strip on hit_strip.
- R3: A hit is rejected unless the group holds at least three consecutive samples, at consecutive indices, that are each strictly above cfg_thresh.
- R4: With cfg_loose=0, acceptance also requires A < C < B, where A, B and C are the samples at indices 0, 1 and 2.
- R5: With cfg_loose=1, acceptance instead requires A < B and C < B, so that both C between A and B and C below A pass.
- R6: hit_pileup is set only when the group has six or more samples. It is set if any sample at index 3, 4 or 5 exceeds B, or if A exceeds cfg_thresh and also exceeds B. It is reported whatever the accept verdict.
- R7: hit_phase equals the trig_phase value presented with the last sample when hit_accept is 1, and is 0 when the hit is rejected.
- R8: After reset, and in every cycle without hit_valid, hit_valid, hit_accept and hit_pileup are 0.
- R9: A sample whose index is not below the current group length is ignored: it is not stored and produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_strip | input | STRIP_W | Strip address of the sample |
| smp_idx | input | 4 | Position of the sample in its group (0 first) |
| smp_data | input | 10 | Sample amplitude, unsigned |
| trig_phase | input | 5 | Trigger-to-clock phase for this event |
| cfg_ntrig | input | 2 | Readout requests per event minus one |
| cfg_thresh | input | 10 | Amplitude threshold |
| cfg_loose | input | 1 | 0 strict ordering, 1 relaxed ordering |
| hit_valid | output | 1 | Verdict present |
| hit_strip | output | STRIP_W | Strip of the verdict |
| hit_accept | output | 1 | Hit is in time |
| hit_pileup | output | 1 | Neighbouring pulse seen |
| hit_phase | output | 5 | Phase of an accepted hit, else 0 |

## Verification
Three-sample groups are driven with the rising, falling, peaked and late-peaked orderings under both ordering modes. These groups separate the strict test from the relaxed one, because a pulse whose third sample falls below its first passes only the relaxed test. Six-sample groups show each of the two pile-up causes apart from a clean tail, and a group whose threshold run starts late shows that the run may lie anywhere in the group. Twelve-sample groups, interleaved strips and stray out-of-range indices probe the per-strip store, the end-of-group detection and the ignore rule.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int ADC_W     = 10;
  localparam int PHASE_W   = 5;
  localparam int TRIG_SAMP = 3;
  localparam int MAX_TRIG  = 4;
  localparam int MAX_SAMP  = TRIG_SAMP * MAX_TRIG;
  localparam int IDX_W     = $clog2(MAX_SAMP);
  localparam int PILE_MIN  = 2 * TRIG_SAMP;

  typedef logic [ADC_W-1:0] adc_t;
  typedef adc_t [MAX_SAMP-1:0] group_t;

  function automatic logic [IDX_W-1:0] group_len(input logic [1:0] ntrig);
    return IDX_W'((int'(ntrig) + 1) * TRIG_SAMP);
  endfunction

  // three consecutive above-threshold samples inside the first len entries
  function automatic logic run_ok(input group_t g, input adc_t thr,
                                  input logic [IDX_W-1:0] len);
    int streak;
    logic ok;
    streak = 0;
    ok = 1'b0;
    for (int k = 0; k < MAX_SAMP; k++) begin
      if ((k < int'(len)) && (g[k] > thr)) streak++;
      else streak = 0;
      if (streak >= TRIG_SAMP) ok = 1'b1;
    end
    return ok;
  endfunction

  function automatic logic order_ok(input group_t g, input logic loose);
    if (loose) return (g[1] > g[0]) && (g[1] > g[2]);
    return (g[0] < g[2]) && (g[2] < g[1]);
  endfunction

  function automatic logic pileup_ok(input group_t g, input adc_t thr,
                                     input logic [IDX_W-1:0] len);
    logic late;
    if (int'(len) < PILE_MIN) return 1'b0;
    late = 1'b0;
    for (int k = TRIG_SAMP; k < PILE_MIN; k++)
      if (g[k] > g[1]) late = 1'b1;
    return late || ((g[0] > thr) && (g[0] > g[1]));
  endfunction
endpackage

// File: rtl/hts_sample_store.sv
module hts_sample_store
  import hts_pkg::*;
#(
  parameter int STRIPS  = 8,
  parameter int STRIP_W = $clog2(STRIPS)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [STRIP_W-1:0] wr_strip,
  input  logic [IDX_W-1:0]   wr_idx,
  input  adc_t               wr_data,
  output group_t             rd_group
);
  group_t mem [STRIPS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_strip][wr_idx] <= wr_data;
  end

  // view of the addressed strip with the incoming sample merged in
  always_comb begin
    rd_group = mem[wr_strip];
    if (wr_en) rd_group[wr_idx] = wr_data;
  end
endmodule

// File: rtl/hts_verdict.sv
module hts_verdict
  import hts_pkg::*;
(
  input  group_t           grp,
  input  adc_t             thresh,
  input  logic [IDX_W-1:0] len,
  input  logic             loose,
  output logic             run_hit,
  output logic             order_hit,
  output logic             accept,
  output logic             pileup
);
  always_comb begin
    run_hit   = run_ok(grp, thresh, len);
    order_hit = order_ok(grp, loose);
    accept    = run_hit && order_hit;
    pileup    = pileup_ok(grp, thresh, len);
  end
endmodule

// File: rtl/hts_out_stage.sv
module hts_out_stage
  import hts_pkg::*;
#(
  parameter int STRIP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [STRIP_W-1:0] strip_in,
  input  logic               accept_in,
  input  logic               pileup_in,
  input  logic [PHASE_W-1:0] phase_in,
  output logic               hit_valid,
  output logic [STRIP_W-1:0] hit_strip,
  output logic               hit_accept,
  output logic               hit_pileup,
  output logic [PHASE_W-1:0] hit_phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid  <= 1'b0;
      hit_strip  <= '0;
      hit_accept <= 1'b0;
      hit_pileup <= 1'b0;
      hit_phase  <= '0;
    end else begin
      hit_valid  <= fire;
      hit_accept <= fire && accept_in;
      hit_pileup <= fire && pileup_in;
      hit_phase  <= (fire && accept_in) ? phase_in : '0;
      if (fire) hit_strip <= strip_in;
    end
  end
endmodule

// File: rtl/hts_selector.sv
module hts_selector
  import hts_pkg::*;
#(
  parameter int STRIPS  = 8,
  parameter int STRIP_W = $clog2(STRIPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [STRIP_W-1:0] smp_strip,
  input  logic [IDX_W-1:0]   smp_idx,
  input  logic [ADC_W-1:0]   smp_data,
  input  logic [PHASE_W-1:0] trig_phase,
  input  logic [1:0]         cfg_ntrig,
  input  logic [ADC_W-1:0]   cfg_thresh,
  input  logic               cfg_loose,
  output logic               hit_valid,
  output logic [STRIP_W-1:0] hit_strip,
  output logic               hit_accept,
  output logic               hit_pileup,
  output logic [PHASE_W-1:0] hit_phase
);
  logic [IDX_W-1:0] grp_len;
  logic             idx_in_range;
  logic             wr_en;
  logic             last_seen;
  group_t           cur_group;
  logic             v_run, v_order, v_accept, v_pileup;

  assign grp_len      = group_len(cfg_ntrig);
  assign idx_in_range = smp_idx < grp_len;
  assign wr_en        = smp_valid && idx_in_range;
  assign last_seen    = wr_en && (smp_idx == grp_len - IDX_W'(1));

  hts_sample_store #(.STRIPS(STRIPS), .STRIP_W(STRIP_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_strip(smp_strip), .wr_idx(smp_idx),
    .wr_data(smp_data), .rd_group(cur_group)
  );

  hts_verdict u_verdict (
    .grp(cur_group), .thresh(cfg_thresh), .len(grp_len), .loose(cfg_loose),
    .run_hit(v_run), .order_hit(v_order), .accept(v_accept), .pileup(v_pileup)
  );

  hts_out_stage #(.STRIP_W(STRIP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(last_seen), .strip_in(smp_strip),
    .accept_in(v_accept), .pileup_in(v_pileup), .phase_in(trig_phase),
    .hit_valid(hit_valid), .hit_strip(hit_strip), .hit_accept(hit_accept),
    .hit_pileup(hit_pileup), .hit_phase(hit_phase)
  );
endmodule

// File: rtl/hts_selector_chk.sv
module hts_selector_chk
  import hts_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               last_seen,
  input logic               v_run,
  input logic [1:0]         cfg_ntrig,
  input logic [PHASE_W-1:0] trig_phase,
  input logic               hit_valid,
  input logic               hit_accept,
  input logic               hit_pileup,
  input logic [PHASE_W-1:0] hit_phase
);
  AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) last_seen |=> hit_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !last_seen |=> !hit_valid); // R2
  AST_RUN_NEEDED: assert property (@(posedge clk) disable iff (!rst_n) (last_seen && !v_run) |=> !hit_accept); // R3
  AST_SHORT_NO_PILE: assert property (@(posedge clk) disable iff (!rst_n) (last_seen && cfg_ntrig == 2'd0) |=> !hit_pileup); // R6
  AST_PHASE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (last_seen) |=> (!hit_accept || hit_phase == $past(trig_phase))); // R7
  AST_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (hit_valid && !hit_accept) |-> hit_phase == '0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !hit_valid |-> (!hit_accept && !hit_pileup)); // R8
endmodule

bind hts_selector hts_selector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .last_seen(last_seen), .v_run(v_run),
  .cfg_ntrig(cfg_ntrig), .trig_phase(trig_phase), .hit_valid(hit_valid),
  .hit_accept(hit_accept), .hit_pileup(hit_pileup), .hit_phase(hit_phase)
);

// File: tb/hts_selector_tb_top.sv
module hts_selector_tb_top;
  localparam int STRIPS = 8;
  localparam int SW = $clog2(STRIPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [SW-1:0] smp_strip = '0;
  logic [3:0] smp_idx = '0;
  logic [9:0] smp_data = '0;
  logic [4:0] trig_phase = '0;
  logic [1:0] cfg_ntrig = '0;
  logic [9:0] cfg_thresh = 10'd100;
  logic cfg_loose = 1'b0;
  logic hit_valid, hit_accept, hit_pileup;
  logic [SW-1:0] hit_strip;
  logic [4:0] hit_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {int strip; bit acc; bit pile; int phase; string req;} exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hts_selector #(.STRIPS(STRIPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_strip(smp_strip),
    .smp_idx(smp_idx), .smp_data(smp_data), .trig_phase(trig_phase),
    .cfg_ntrig(cfg_ntrig), .cfg_thresh(cfg_thresh), .cfg_loose(cfg_loose),
    .hit_valid(hit_valid), .hit_strip(hit_strip), .hit_accept(hit_accept),
    .hit_pileup(hit_pileup), .hit_phase(hit_phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent reference: peak test, threshold streak, neighbour test
  function automatic void model(input int v[12], input int n, input int thr,
                                input bit loose, output bit acc, output bit pile);
    bit shape, run;
    int best;
    if (loose) shape = (v[1] > v[0]) && (v[2] < v[1]);
    else shape = (v[2] > v[0]) && (v[1] > v[2]);
    run = 1'b0;
    for (int s = 0; s + 2 < n; s++)
      if (v[s] > thr && v[s+1] > thr && v[s+2] > thr) run = 1'b1;
    acc = shape && run;
    pile = 1'b0;
    if (n >= 6) begin
      best = v[3];
      if (v[4] > best) best = v[4];
      if (v[5] > best) best = v[5];
      pile = (best > v[1]) || (v[0] > thr && v[0] > v[1]);
    end
  endfunction

  task automatic drive(input int st, input int ix, input int d, input int ph);
    @(negedge clk);
    smp_valid = 1'b1; smp_strip = SW'(st); smp_idx = 4'(ix);
    smp_data = 10'(d); trig_phase = 5'(ph);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic push(input int st, input int v[12], input int n, input int ph, input string req);
    exp_t e;
    model(v, n, int'(cfg_thresh), cfg_loose, e.acc, e.pile);
    e.strip = st; e.phase = e.acc ? ph : 0; e.req = req;
    sb.push_back(e);
  endtask

  task automatic send(input int st, input int v[12], input int ph, input string req);
    int n;
    n = 3 * (int'(cfg_ntrig) + 1);
    for (int k = 0; k < n; k++) drive(st, k, v[k], ph);
    push(st, v, n, ph, req);
    idle(2);
  endtask

  // monitor: compare each verdict with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && hit_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2/R9 unexpected verdict", int'(hit_strip), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(int'(hit_strip) == e.strip, "R1 strip", int'(hit_strip), e.strip);
        chk(hit_accept == e.acc, e.req, int'(hit_accept), int'(e.acc));
        chk(hit_pileup == e.pile, "R6 pileup", int'(hit_pileup), int'(e.pile));
        chk(int'(hit_phase) == e.phase, "R7 phase", int'(hit_phase), e.phase);
      end
    end
  end

  initial begin
    int g[12];
    int ga[12];
    int gb[12];
    int n;
    repeat (3) @(negedge clk);
    chk(hit_valid == 1'b0, "R8 reset valid", int'(hit_valid), 0);
    chk(hit_accept == 1'b0, "R8 reset accept", int'(hit_accept), 0);
    chk(hit_pileup == 1'b0, "R8 reset pileup", int'(hit_pileup), 0);
    rst_n = 1'b1;
    idle(2);

    cfg_ntrig = 2'd0; cfg_loose = 1'b0;
    g = '{150, 300, 200, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(1, g, 7, "R4 strict peaked");
    g = '{200, 300, 150, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(2, g, 9, "R4 strict late tail");
    g = '{150, 200, 300, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(3, g, 11, "R4 strict rising");
    g = '{50, 300, 200, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(4, g, 13, "R3 below threshold");
    cfg_loose = 1'b1;
    g = '{200, 300, 150, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(2, g, 17, "R5 loose late tail");
    g = '{150, 300, 200, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(5, g, 19, "R5 loose peaked");
    g = '{300, 200, 150, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(5, g, 21, "R5 loose falling");

    cfg_loose = 1'b0; cfg_ntrig = 2'd1;
    g = '{150, 300, 200, 120, 110, 105, 0, 0, 0, 0, 0, 0};
    send(0, g, 3, "R6 clean tail");
    g = '{150, 300, 200, 120, 400, 110, 0, 0, 0, 0, 0, 0};
    send(0, g, 4, "R6 late pulse");
    g = '{400, 300, 200, 50, 50, 50, 0, 0, 0, 0, 0, 0};
    send(6, g, 5, "R6 early pulse");
    g = '{50, 300, 200, 150, 20, 20, 0, 0, 0, 0, 0, 0};
    send(7, g, 6, "R3 run not at start");

    cfg_ntrig = 2'd3;
    g = '{150, 300, 200, 180, 160, 140, 130, 120, 115, 110, 105, 102};
    send(3, g, 31, "R2 twelve samples");

    // R1: two strips interleaved, strip 2 completes first
    cfg_ntrig = 2'd1;
    ga = '{150, 300, 200, 120, 110, 105, 0, 0, 0, 0, 0, 0};
    gb = '{200, 300, 150, 120, 110, 105, 0, 0, 0, 0, 0, 0};
    n = 6;
    for (int k = 0; k < n; k++) begin
      drive(2, k, ga[k], 8);
      if (k == n - 1) push(2, ga, n, 8, "R1 interleave A");
      drive(5, k, gb[k], 8);
      if (k == n - 1) push(5, gb, n, 8, "R1 interleave B");
    end
    idle(2);

    // R9: out-of-range indices under a three-sample group
    cfg_ntrig = 2'd0;
    drive(3, 5, 999, 2);
    drive(3, 3, 999, 2);
    idle(3);
    g = '{150, 300, 200, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    send(3, g, 22, "R9 group after stray");

    idle(4);
    chk(sb.size() == 0, "R2 outstanding verdicts", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule